// File: doc/BRIEF.md
# DRAM access and refresh sequencer

This block produces the strobe and handshake timing for an asynchronous DRAM. It shares the memory between processor accesses and periodic refresh. A processor requests an access by pulling `acc_req_n` low and holds it low for the whole access. The sequencer answers with `grant`, opens the row with `ras_n`, and strobes the column half a clock later than the rising edge on which the column would otherwise be strobed. It then signals completion on `ack_n`. `ack_n` is driven only while `ack_oe` is high.

Refresh requests are made from a slow, unrelated clock, `rfsh_clk`. That clock is synchronized into the main domain and divided down. Each request latches until a four-cycle, row-only refresh services it. The row for that refresh is taken from `rfsh_addr`, and the address path uses `rfsh_active` to select it. Two strap-style inputs set the timing. `pre_short` selects the precharge length. `row_hold_short` selects when `col_phase` switches the address path from row to column. `row_strobe_start` pulses once at the start of every cycle.

Top module: `dram_seq`

## Requirements
- R1: While reset is asserted and after it: `ras_n`, `cas_n` and `ack_n` are high, and `grant`, `rfsh_active`, `row_strobe_start`, `col_phase` and `rfsh_addr` are zero.
- R2: An access starts on the first rising edge that meets all of these conditions: it samples `acc_req_n` low, no cycle is in progress, precharge is complete, and no refresh is pending. On that edge `ras_n` falls and `grant` rises. `row_strobe_start` is high for exactly the first cycle of every access or refresh.
- R3: If `keep_open_n` is high on the start edge, `ras_n` stays low for four cycles. It negates earlier if `acc_req_n` is sampled high first.
- R4: If `keep_open_n` is low on the start edge, `ras_n` stays low until the first rising edge that samples `keep_open_n` or `acc_req_n` high.
- R5: `cas_n` falls on the falling edge 1.5 cycles after `ras_n` falls, provided the access is still active. The access ends on the first rising edge that samples `acc_req_n` high. On that edge `grant` drops, and `cas_n` rises at the next falling edge.
- R6: `ack_oe` equals the inverse of `acc_req_n` at all times. `ack_n` falls four cycles after `ras_n` falls if the access is still active, and rises when the access ends.
- R7: With `row_hold_short` high, `col_phase` rises half a cycle after `ras_n` falls and drops half a cycle after the access ends. With `row_hold_short` low, `col_phase` rises one cycle after `ras_n` falls and drops when the access ends.
- R8: After `ras_n` negates, it stays high for at least 3 cycles if `pre_short` was high on the negating edge, and at least 4 cycles if it was low. A new cycle starts as soon as this minimum has passed and its other conditions hold.
- R9: A refresh request is raised on every 64th rising edge of `rfsh_clk`, counted after synchronization. The request stays pending until a refresh cycle starts.
- R10: A refresh cycle holds `ras_n` and `rfsh_active` low and high respectively for exactly four cycles. During it, `grant` stays low, `cas_n` stays high, and `keep_open_n` has no effect.
- R11: When a refresh is pending and `acc_req_n` is low at the same start point, the refresh runs first.
- R12: `rfsh_addr` increments by one on the edge that ends each refresh cycle and wraps from 1023 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock; the falling edge times half-cycle events |
| rst_n | input | 1 | Asynchronous reset, active low |
| rfsh_clk | input | 1 | Slow refresh time base, asynchronous to `clk` |
| acc_req_n | input | 1 | Access request, active low |
| keep_open_n | input | 1 | Page-hold request, active low |
| row_hold_short | input | 1 | 1: column switch after half a cycle, 0: after a full cycle |
| pre_short | input | 1 | 1: 3-cycle precharge, 0: 4-cycle precharge |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| grant | output | 1 | Processor access in progress |
| ack_n | output | 1 | Transfer acknowledge, active low |
| ack_oe | output | 1 | Output enable for `ack_n` |
| rfsh_active | output | 1 | Refresh cycle in progress |
| row_strobe_start | output | 1 | One-cycle pulse at the start of each cycle |
| rfsh_addr | output | 10 | Refresh row counter |
| col_phase | output | 1 | Address path selects column when high |

## Verification
The access sweep covers both page settings, both precharge lengths and both column-switch settings. For each combination it varies how many cycles the request is held, and in page mode it also varies when the page-hold input is released. The short holds separate requests that end before the column strobe or the acknowledge from those that outlast them. The page-release sweep separates a row held open by the page input from one closed by the request. In every run a second request follows at once, so the gap between the two row strobes shows the precharge length.

Refresh runs check the exact divide count and the fixed strobe window. They also hold a request against a pending refresh to show that refresh takes priority. A second instance with a short divider runs past 1024 refreshes to show the counter wrap.

// File: rtl/dram_seq.sv
`timescale 1ns/1ps
module dram_seq #(
  parameter int DIV_LOG2 = 6,
  parameter int ROW_W = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rfsh_clk,
  input  logic acc_req_n,
  input  logic keep_open_n,
  input  logic row_hold_short,
  input  logic pre_short,
  output logic ras_n,
  output logic cas_n,
  output logic grant,
  output logic ack_n,
  output logic ack_oe,
  output logic rfsh_active,
  output logic row_strobe_start,
  output logic [ROW_W-1:0] rfsh_addr,
  output logic col_phase
);
  logic [2:0] rsync;
  logic [DIV_LOG2-1:0] div_cnt;
  logic pend, page_mode, col_full, col_half;
  logic [2:0] cnt;
  logic [1:0] pc;

  wire tick    = rsync[1] & ~rsync[2];
  wire rq_tick = tick & (&div_cnt);
  wire idle    = !grant && !rfsh_active && ras_n && (pc == 2'd0);
  wire start_r = idle && pend;
  wire start_a = idle && !pend && !acc_req_n;
  wire ras_neg = !ras_n && ((rfsh_active && cnt == 3'd3) ||
                 (grant && (acc_req_n || (page_mode ? keep_open_n : cnt == 3'd3))));

  assign ack_oe    = !acc_req_n;
  assign col_phase = row_hold_short ? col_half : col_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsync <= '0;
      div_cnt <= '0;
      pend <= 1'b0;
      row_strobe_start <= 1'b0;
      cnt <= '0;
      ras_n <= 1'b1;
      pc <= '0;
      rfsh_active <= 1'b0;
      rfsh_addr <= '0;
      grant <= 1'b0;
      page_mode <= 1'b0;
      ack_n <= 1'b1;
      col_full <= 1'b0;
    end else begin
      rsync <= {rsync[1:0], rfsh_clk};
      if (tick) div_cnt <= div_cnt + 1'b1;
      if (rq_tick) pend <= 1'b1;
      else if (start_r) pend <= 1'b0;
      row_strobe_start <= start_r | start_a;

      if (start_r | start_a) cnt <= '0;
      else if ((grant | rfsh_active) && cnt != 3'd7) cnt <= cnt + 3'd1;

      if (start_r | start_a) ras_n <= 1'b0;
      else if (ras_neg) ras_n <= 1'b1;

      if (ras_neg) pc <= pre_short ? 2'd2 : 2'd3;
      else if (pc != 2'd0) pc <= pc - 2'd1;

      if (start_r) rfsh_active <= 1'b1;
      else if (rfsh_active && cnt == 3'd3) begin
        rfsh_active <= 1'b0;
        rfsh_addr <= rfsh_addr + 1'b1;
      end

      if (start_a) begin
        grant <= 1'b1;
        page_mode <= !keep_open_n;
      end else if (grant && acc_req_n) begin
        grant <= 1'b0;
        ack_n <= 1'b1;
        col_full <= 1'b0;
      end else if (grant) begin
        if (cnt == 3'd0) col_full <= 1'b1;
        if (cnt == 3'd3) ack_n <= 1'b0;
      end
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cas_n <= 1'b1;
      col_half <= 1'b0;
    end else begin
      cas_n <= !(grant && cnt != 3'd0);
      col_half <= grant;
    end
  end
endmodule

// File: rtl/dram_seq_chk.sv
`timescale 1ns/1ps
module dram_seq_chk #(
  parameter int ROW_W = 10
) (
  input logic clk,
  input logic rst_n,
  input logic ras_n,
  input logic cas_n,
  input logic grant,
  input logic ack_n,
  input logic rfsh_active,
  input logic row_strobe_start,
  input logic [ROW_W-1:0] rfsh_addr
);
  p_start_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    row_strobe_start |-> !ras_n && $past(ras_n));
  p_grant_opens_row_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grant) |-> $fell(ras_n));
  p_cas_in_access_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !cas_n |-> grant);
  p_ack_in_access_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_n |-> grant);
  p_min_precharge_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> $past(ras_n, 2) && $past(ras_n, 3));
  p_rfsh_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(grant && rfsh_active));
  p_rfsh_row_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rfsh_active |-> !ras_n);
  p_rfsh_len_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rfsh_active) |=> rfsh_active ##1 rfsh_active ##1 rfsh_active ##1 !rfsh_active);
  p_row_step_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rfsh_active) |-> rfsh_addr == $past(rfsh_addr) + ROW_W'(1));
endmodule

bind dram_seq dram_seq_chk #(.ROW_W(ROW_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .grant(grant),
  .ack_n(ack_n), .rfsh_active(rfsh_active), .row_strobe_start(row_strobe_start),
  .rfsh_addr(rfsh_addr)
);

// File: tb/tb_dram_seq.sv
`timescale 1ns/1ps
module tb_dram_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rfsh_clk = 1'b0, acc_req_n = 1'b1, keep_open_n = 1'b1;
  logic row_hold_short = 1'b0, pre_short = 1'b0;
  logic ras_n, cas_n, grant, ack_n, ack_oe, rfsh_active, row_strobe_start, col_phase;
  logic [9:0] rfsh_addr;

  logic rcp_f = 1'b0;
  logic ras_f, cas_f, gnt_f, ack_f, oe_f, rfa_f, st_f, col_f;
  logic [9:0] addr_f;

  int vectors = 0, miscompares = 0, rf_rises = 0;

  logic t_ras[64], t_cas[64], t_gnt[64], t_ack[64], t_oe[64], t_req[64];
  logic t_col[64], t_st[64], t_rfa[64];

  always #5 clk = ~clk;

  dram_seq dut (
    .clk(clk), .rst_n(rst_n), .rfsh_clk(rfsh_clk), .acc_req_n(acc_req_n),
    .keep_open_n(keep_open_n), .row_hold_short(row_hold_short), .pre_short(pre_short),
    .ras_n(ras_n), .cas_n(cas_n), .grant(grant), .ack_n(ack_n), .ack_oe(ack_oe),
    .rfsh_active(rfsh_active), .row_strobe_start(row_strobe_start),
    .rfsh_addr(rfsh_addr), .col_phase(col_phase)
  );

  dram_seq #(.DIV_LOG2(1)) dut_fast (
    .clk(clk), .rst_n(rst_n), .rfsh_clk(rcp_f), .acc_req_n(1'b1),
    .keep_open_n(1'b1), .row_hold_short(1'b0), .pre_short(1'b1),
    .ras_n(ras_f), .cas_n(cas_f), .grant(gnt_f), .ack_n(ack_f), .ack_oe(oe_f),
    .rfsh_active(rfa_f), .row_strobe_start(st_f), .rfsh_addr(addr_f), .col_phase(col_f)
  );

  always @(posedge rfsh_active) rf_rises++;

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s: got %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      rfsh_clk = 1'b1; cyc(2);
      rfsh_clk = 1'b0; cyc(2);
    end
  endtask

  task automatic sample(input int h);
    t_ras[h] = ras_n; t_cas[h] = cas_n; t_gnt[h] = grant; t_ack[h] = ack_n;
    t_oe[h] = ack_oe; t_req[h] = acc_req_n; t_col[h] = col_phase;
    t_st[h] = row_strobe_start; t_rfa[h] = rfsh_active;
  endtask

  task automatic access_run(input int pg, input int pre, input int hs, input int L, input int Q);
    int S, A, R, N, P;
    string rtag;
    pre_short = pre[0]; row_hold_short = hs[0];
    @(negedge clk);
    for (int h = 0; h < 64; h++) begin
      @(clk); #2;
      if (h % 2 == 0) begin
        acc_req_n = !((h/2 < L) || (h/2 > L && h/2 < L + 13));
        keep_open_n = !(pg != 0 && h/2 < Q);
      end
      #2; sample(h);
    end
    acc_req_n = 1'b1; keep_open_n = 1'b1;
    cyc(12);
    S = 2; A = 2*(L+1); P = pre ? 3 : 4;
    R = pg ? ((2*(Q+1) < A) ? 2*(Q+1) : A) : ((S+8 < A) ? S+8 : A);
    N = (R + 2*P > 2*(L+2)) ? R + 2*P : 2*(L+2);
    rtag = pg ? "R4" : "R3";
    for (int h = 0; h < N; h++) begin
      chk(t_ras[h] == !(h >= S && h < R), rtag, "ras_n", t_ras[h], !(h >= S && h < R));
      chk(t_gnt[h] == (h >= S && h < A), "R2", "grant", t_gnt[h], (h >= S && h < A));
      chk(t_st[h] == (h >= S && h < S+2), "R2", "start pulse", t_st[h], (h >= S && h < S+2));
      chk(t_cas[h] == !(A > S+2 && h >= S+3 && h < A+1), "R5", "cas_n", t_cas[h],
          !(A > S+2 && h >= S+3 && h < A+1));
      chk(t_ack[h] == !(A > S+8 && h >= S+8 && h < A), "R6", "ack_n", t_ack[h],
          !(A > S+8 && h >= S+8 && h < A));
      if (hs != 0)
        chk(t_col[h] == (h >= S+1 && h < A+1), "R7", "col_phase short", t_col[h], (h >= S+1 && h < A+1));
      else
        chk(t_col[h] == (A > S+2 && h >= S+2 && h < A), "R7", "col_phase full", t_col[h],
            (A > S+2 && h >= S+2 && h < A));
    end
    for (int h = 0; h < 64; h++)
      chk(t_oe[h] == !t_req[h], "R6", "ack_oe", t_oe[h], !t_req[h]);
    chk(t_ras[N] == 1'b0, "R8", "second row strobe after precharge", t_ras[N], 0);
    chk(t_gnt[N] == 1'b1, "R8", "second grant", t_gnt[N], 1);
  endtask

  task automatic refresh_watch(input int exp_row);
    @(negedge clk);
    for (int h = 0; h < 40; h++) begin
      @(clk); #2;
      if (h == 0) rfsh_clk = 1'b1;
      if (h == 4) rfsh_clk = 1'b0;
      if (h == 8) keep_open_n = 1'b0;
      #2; sample(h);
    end
    keep_open_n = 1'b1;
    for (int h = 0; h < 40; h++) begin
      chk(t_rfa[h] == (h >= 8 && h < 16), "R10", "rfsh_active window", t_rfa[h], (h >= 8 && h < 16));
      chk(t_ras[h] == !(h >= 8 && h < 16), "R10", "refresh ras_n", t_ras[h], !(h >= 8 && h < 16));
      chk(t_gnt[h] == 1'b0, "R10", "grant in refresh", t_gnt[h], 0);
      chk(t_cas[h] == 1'b1, "R10", "cas_n in refresh", t_cas[h], 1);
    end
    chk(int'(rfsh_addr) == exp_row, "R12", "row after refresh", rfsh_addr, exp_row);
  endtask

  task automatic priority_run(input int pre);
    int P;
    P = pre ? 3 : 4;
    pre_short = pre[0];
    acc_req_n = 1'b0; keep_open_n = 1'b0;
    cyc(4);
    pulses(64);
    cyc(6);
    @(negedge clk);
    for (int h = 0; h < 64; h++) begin
      @(clk); #2;
      if (h == 0) begin acc_req_n = 1'b1; keep_open_n = 1'b1; end
      if (h == 2) acc_req_n = 1'b0;
      #2; sample(h);
    end
    acc_req_n = 1'b1;
    cyc(12);
    for (int h = 2; h < 10 + 4*P; h++)
      chk(t_gnt[h] == 1'b0, "R11", "grant held off by refresh", t_gnt[h], 0);
    for (int h = 2; h < 10 + 2*P; h++)
      chk(t_rfa[h] == (h >= 2 + 2*P), "R11", "refresh first", t_rfa[h], (h >= 2 + 2*P));
    chk(t_ras[10 + 4*P] == 1'b0 && t_gnt[10 + 4*P] == 1'b1, "R11", "access after refresh",
        t_gnt[10 + 4*P], 1);
    chk(t_ras[10 + 4*P - 1] == 1'b1, "R8", "precharge before access", t_ras[10 + 4*P - 1], 1);
  endtask

  initial begin
    #1_000_000;
    miscompares++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    int done;
    logic prev;
    cyc(3);
    chk(ras_n == 1'b1 && cas_n == 1'b1 && ack_n == 1'b1, "R1", "strobes in reset", ras_n & cas_n & ack_n, 1);
    chk(grant == 1'b0 && rfsh_active == 1'b0 && row_strobe_start == 1'b0, "R1", "flags in reset",
        grant | rfsh_active | row_strobe_start, 0);
    chk(rfsh_addr == 10'd0 && col_phase == 1'b0, "R1", "row and col in reset", rfsh_addr, 0);
    rst_n = 1'b1;
    cyc(3);
    chk(ras_n && cas_n && ack_n && !grant && !rfsh_active && rfsh_addr == 0 && !col_phase, "R1",
        "idle after reset", ras_n, 1);

    pulses(63);
    cyc(12);
    chk(rf_rises == 0, "R9", "no refresh after 63 edges", rf_rises, 0);
    refresh_watch(1);
    chk(rf_rises == 1, "R9", "one refresh after 64 edges", rf_rises, 1);
    pulses(63);
    cyc(12);
    chk(rf_rises == 1, "R9", "no refresh after next 63 edges", rf_rises, 1);
    refresh_watch(2);

    for (int pre = 0; pre < 2; pre++)
      for (int hs = 0; hs < 2; hs++)
        for (int L = 1; L <= 9; L++) begin
          access_run(0, pre, hs, L, 0);
          for (int Q = 1; Q <= 7; Q++) access_run(1, pre, hs, L, Q);
        end

    priority_run(0);
    priority_run(1);
    chk(int'(rfsh_addr) == 4, "R12", "row after priority runs", rfsh_addr, 4);

    done = 0; prev = 1'b0;
    for (int k = 0; k < 9000; k++) begin
      @(posedge clk); #2;
      rcp_f = ((k / 2) % 2) != 0;
      if (prev && !rfa_f) begin
        done++;
        chk(int'(addr_f) == done % 1024, "R12", "row counter step", addr_f, done % 1024);
      end
      prev = rfa_f;
    end
    chk(done > 1024, "R12", "counter passed wrap", done, 1025);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule